// File: doc/BRIEF.md
# Two-User OR-Channel Chip Decoder

This block sits behind the threshold detector of a shared optical channel on which two transmitters are combined by a binary OR: a received chip is 1 whenever either user sends a 1. One chip arrives per clock on which `chip_en` is high. The two decoders recover one data bit per code block each. Decoder A serves a user that spends 4 chips per bit, and decoder B serves a user that spends 6 chips per bit. The combined rate is 5/12.

Both users share chip timing, but their block boundaries can be offset from each other. Each decoder therefore keeps its own block-position counter, and its own sync strobe aligns that counter. A decoder looks for the first zero chip in its block and decides the bit from where that zero lies. It reports the bit on the clock after the block's last chip. Nothing is carried from one block to the next.

Top module: `or_chip_pair_decoder`

## Requirements
- R1: A synchronous active-high reset clears `valid_a`, `valid_b`, `err_a`, `err_b`, `bit_a` and `bit_b` to 0 and puts both block counters at chip position 1.
- R2: Decoder A decodes 1 when the first zero chip of its 4-chip block sits at position 1 or 2. It decodes 0 when that zero sits at position 3 or 4.
- R3: Decoder B decodes 1 when the first zero chip of its 6-chip block sits at position 1, 3 or 5. It decodes 0 when that zero sits at position 2, 4 or 6.
- R4: When a block holds several zero chips, only the earliest one decides the bit.
- R5: `valid_a` or `valid_b` is high for exactly one clock. That clock follows the edge that sampled the 4th (A) or 6th (B) accepted chip of the block. The decoded bit appears on the same clock.
- R6: When a block ends without any zero chip, the decoder raises its `err` output together with `valid` and outputs bit 0.
- R7: A high `sync_a` or `sync_b` together with `chip_en` marks the current chip as position 1 of that decoder only. Any partial block in progress is discarded.
- R8: While `chip_en` is low, the chip and sync inputs are ignored and neither block counter moves.
- R9: Each block is decoded on its own. A zero seen in an earlier block never counts for a later block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_en | input | 1 | Chip valid strobe |
| chip | input | 1 | Thresholded channel chip |
| sync_a | input | 1 | Marks position 1 for decoder A |
| sync_b | input | 1 | Marks position 1 for decoder B |
| bit_a | output | 1 | Decoded bit, 4-chip user |
| valid_a | output | 1 | One-clock strobe for bit_a |
| err_a | output | 1 | Block of A held no zero |
| bit_b | output | 1 | Decoded bit, 6-chip user |
| valid_b | output | 1 | One-clock strobe for bit_b |
| err_b | output | 1 | Block of B held no zero |

## Verification
The bench aims at these corner cases:
- **Zero at a half or parity boundary.** Zeros are placed at position 2 versus 3 for A, and at positions 5 and 6 for B. A wrong split would flip the decided bit.
- **Later zeros.** Blocks carry extra zeros after the first one. A decoder that kept the last zero instead of the first would return the wrong bit.
- **Blocks with no zero.** These catch a missing error pulse. Placing such a block right after a block with a zero catches a found-flag that leaks across blocks.
- **Gaps and syncs.** Gaps in `chip_en` and mid-block sync strobes on one decoder only would expose a counter that drifts, advances on idle clocks, or couples the two phases. These show up as valid strobes on the wrong clock.

// File: rtl/or_chip_pair_decoder.sv
module or_chip_pair_decoder #(
  parameter int LEN_A = 4,
  parameter int LEN_B = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic chip_en,
  input  logic chip,
  input  logic sync_a,
  input  logic sync_b,
  output logic bit_a,
  output logic valid_a,
  output logic err_a,
  output logic bit_b,
  output logic valid_b,
  output logic err_b
);
  localparam int WA = $clog2(LEN_A);
  localparam int WB = $clog2(LEN_B);

  logic [WA-1:0] pos_a, idx_a, fz_a, fz_a_n;
  logic          fnd_a, fnd_a_n, last_a;
  logic [WB-1:0] pos_b, idx_b, fz_b, fz_b_n;
  logic          fnd_b, fnd_b_n, last_b;

  assign idx_a   = sync_a ? '0 : pos_a;
  assign last_a  = idx_a == WA'(LEN_A - 1);
  assign fnd_a_n = (idx_a == '0) ? ~chip : (fnd_a | ~chip);
  assign fz_a_n  = (idx_a != '0 && fnd_a) ? fz_a : idx_a;

  assign idx_b   = sync_b ? '0 : pos_b;
  assign last_b  = idx_b == WB'(LEN_B - 1);
  assign fnd_b_n = (idx_b == '0) ? ~chip : (fnd_b | ~chip);
  assign fz_b_n  = (idx_b != '0 && fnd_b) ? fz_b : idx_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_a   <= '0;
      fnd_a   <= 1'b0;
      fz_a    <= '0;
      valid_a <= 1'b0;
      err_a   <= 1'b0;
      bit_a   <= 1'b0;
    end else begin
      valid_a <= 1'b0;
      err_a   <= 1'b0;
      if (chip_en) begin
        fnd_a <= fnd_a_n;
        fz_a  <= fz_a_n;
        pos_a <= last_a ? '0 : idx_a + 1'b1;
        if (last_a) begin
          valid_a <= 1'b1;
          err_a   <= ~fnd_a_n;
          bit_a   <= fnd_a_n && (fz_a_n < WA'(LEN_A / 2));
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_b   <= '0;
      fnd_b   <= 1'b0;
      fz_b    <= '0;
      valid_b <= 1'b0;
      err_b   <= 1'b0;
      bit_b   <= 1'b0;
    end else begin
      valid_b <= 1'b0;
      err_b   <= 1'b0;
      if (chip_en) begin
        fnd_b <= fnd_b_n;
        fz_b  <= fz_b_n;
        pos_b <= last_b ? '0 : idx_b + 1'b1;
        if (last_b) begin
          valid_b <= 1'b1;
          err_b   <= ~fnd_b_n;
          bit_b   <= fnd_b_n && !fz_b_n[0];
        end
      end
    end
  end
endmodule

// File: rtl/or_chip_pair_decoder_checks.sv
module or_chip_pair_decoder_checks (
  input logic clk,
  input logic rst,
  input logic chip_en,
  input logic bit_a,
  input logic valid_a,
  input logic err_a,
  input logic bit_b,
  input logic valid_b,
  input logic err_b
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> !valid_a && !valid_b && !err_a && !err_b && !bit_a && !bit_b);

  a_r5_valid_a_single: assert property (@(posedge clk) disable iff (rst)
    valid_a |=> !valid_a);

  a_r5_valid_b_single: assert property (@(posedge clk) disable iff (rst)
    valid_b |=> !valid_b);

  a_r6_err_a_with_valid: assert property (@(posedge clk) disable iff (rst)
    err_a |-> valid_a && !bit_a);

  a_r6_err_b_with_valid: assert property (@(posedge clk) disable iff (rst)
    err_b |-> valid_b && !bit_b);

  a_r8_idle_no_valid: assert property (@(posedge clk) disable iff (rst)
    !chip_en |=> !valid_a && !valid_b);
endmodule

bind or_chip_pair_decoder or_chip_pair_decoder_checks u_checks (.*);

// File: tb/test_or_chip_pair_decoder.sv
`timescale 1ns/1ps
module test_or_chip_pair_decoder;
  localparam int LA = 4;
  localparam int LB = 6;

  logic clk = 0, rst = 1, chip_en = 0, chip = 0, sync_a = 0, sync_b = 0;
  logic bit_a, valid_a, err_a, bit_b, valid_b, err_b;
  int total = 0, bad = 0;
  bit done = 0;

  int pa = 0, pb = 0;
  bit ca[LA];
  bit cb[LB];
  bit ev_a, eb_a, ee_a, ev_b, eb_b, ee_b;

  always #2.5 clk = ~clk;

  or_chip_pair_decoder i_or_chip_pair_decoder (.*);

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int first_zero_a();
    for (int i = 0; i < LA; i++) if (!ca[i]) return i;
    return -1;
  endfunction

  function automatic int first_zero_b();
    for (int i = 0; i < LB; i++) if (!cb[i]) return i;
    return -1;
  endfunction

  task automatic step(bit en, bit c, bit sa, bit sb);
    int fz;
    chip_en = en; chip = c; sync_a = sa; sync_b = sb;
    ev_a = 0; ev_b = 0;
    if (en) begin
      if (sa) pa = 0;
      ca[pa] = c; pa++;
      if (pa == LA) begin
        pa = 0; ev_a = 1;
        fz = first_zero_a();
        ee_a = (fz < 0);
        eb_a = (fz >= 0) && (fz < LA / 2);
      end
      if (sb) pb = 0;
      cb[pb] = c; pb++;
      if (pb == LB) begin
        pb = 0; ev_b = 1;
        fz = first_zero_b();
        ee_b = (fz < 0);
        eb_b = (fz >= 0) && (fz % 2 == 0);
      end
    end
    @(posedge clk); #1;
    chk(valid_a === ev_a, "R5 valid_a timing", valid_a, ev_a);
    chk(valid_b === ev_b, "R5 valid_b timing", valid_b, ev_b);
    if (ev_a) begin
      chk(bit_a === eb_a, "R2 bit_a", bit_a, eb_a);
      chk(err_a === ee_a, "R6 err_a", err_a, ee_a);
    end else chk(err_a === 1'b0, "R6 err_a idle", err_a, 0);
    if (ev_b) begin
      chk(bit_b === eb_b, "R3 bit_b", bit_b, eb_b);
      chk(err_b === ee_b, "R6 err_b", err_b, ee_b);
    end else chk(err_b === 1'b0, "R6 err_b idle", err_b, 0);
    chip_en = 0; chip = 0; sync_a = 0; sync_b = 0;
  endtask

  task automatic block(int n, logic [5:0] pat, bit sa, bit sb);
    for (int i = 0; i < n; i++) step(1, pat[n-1-i], sa && i == 0, sb && i == 0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4127));
    repeat (3) @(posedge clk);
    #1;
    rst = 0;
    chk(valid_a === 0 && valid_b === 0 && err_a === 0 && err_b === 0,
        "R1 reset valid/err", {valid_a, valid_b, err_a, err_b}, 0);
    chk(bit_a === 0 && bit_b === 0, "R1 reset bits", {bit_a, bit_b}, 0);

    block(4, 6'b0111, 1, 1);
    chk(valid_a === 1 && bit_a === 1, "R2 zero at pos1", bit_a, 1);
    block(4, 6'b1101, 0, 0);
    chk(bit_a === 0, "R2 zero at pos3", bit_a, 0);
    block(4, 6'b1011, 0, 0);
    chk(bit_a === 1, "R2 zero at pos2", bit_a, 1);
    block(4, 6'b1110, 0, 0);
    chk(bit_a === 0, "R2 zero at pos4", bit_a, 0);

    block(6, 6'b111101, 1, 1);
    chk(valid_b === 1 && bit_b === 1, "R3 zero at pos5", bit_b, 1);
    block(6, 6'b111110, 1, 1);
    chk(bit_b === 0, "R3 zero at pos6", bit_b, 0);
    block(6, 6'b101010, 1, 1);
    chk(bit_b === 0, "R4 first zero pos2 of many", bit_b, 0);
    block(4, 6'b1010, 1, 1);
    chk(bit_a === 1, "R4 first zero pos2 of two", bit_a, 1);

    block(4, 6'b0000, 1, 1);
    block(4, 6'b1111, 0, 0);
    chk(err_a === 1 && bit_a === 0, "R9 no leak into zero-free block", err_a, 1);
    chk(valid_a === 1, "R6 err with valid", valid_a, 1);

    step(1, 0, 1, 1);
    step(1, 1, 0, 0);
    repeat (3) step(0, 0, 1, 1);
    chk(valid_a === 0, "R8 idle chips ignored", valid_a, 0);
    step(1, 1, 0, 0);
    step(1, 1, 0, 0);
    chk(valid_a === 1 && bit_a === 1, "R8 block resumes after gap", bit_a, 1);

    step(1, 0, 1, 1);
    step(1, 0, 0, 0);
    step(1, 1, 1, 0);
    step(1, 1, 0, 0);
    step(1, 1, 0, 0);
    chk(valid_a === 0, "R7 sync_a restarted block", valid_a, 0);
    step(1, 1, 0, 0);
    chk(valid_a === 1 && err_a === 1, "R7 restart discarded zeros", err_a, 1);
    chk(valid_b === 1 && bit_b === 1, "R7 sync_a left B alone", bit_b, 1);

    for (int k = 0; k < 20000; k++) begin
      int r;
      r = $urandom_range(0, 99);
      step(r < 85, ($urandom_range(0, 99) < 70),
           $urandom_range(0, 99) < 4, $urandom_range(0, 99) < 4);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule